// File: doc/BRIEF.md
# UHF Channel Synthesizer Digital Core

This block is the digital half of the phase-locked loop that places a UHF television channel carrier. A crystal clock of nominally 4 MHz feeds a free-running reference counter. The counter sets the phase comparison rate at crystal/128, which is 31.25 kHz. It also issues slower single-cycle ticks for a sound-subcarrier loop and for an audio test tone. The oscillator, already divided by a fixed factor of eight outside this block, arrives on a second clock. A programmable 12-bit divider divides that clock by N, so each step of N moves the carrier by 250 kHz.

A tri-state phase-frequency detector compares the two divided signals and produces enables for the upper (sourcing) and lower (sinking) current sources of an external charge pump. A three-bit test code and a two-bit auxiliary code choose the pump polarity at run time. They can also force either source on, float the output, or route a divider output straight onto one source. This lets each divider be measured on the pump pin.

Top module: `uhf_synth_digital`

## Requirements
- R1: While `rst_n` is low, `pump_up`, `pump_dn`, `pump_hiz`, `cmp_tick`, `snd_tick` and `tone_tick` are all 0.
- R2: `cmp_tick` is a one-cycle pulse that occurs once every 128 crystal cycles.
- R3: `snd_tick` recurs every 512 crystal cycles and `tone_tick` every 4096. A `tone_tick` pulse always coincides with a `snd_tick` pulse, and a `snd_tick` pulse always coincides with a `cmp_tick` pulse.
- R4: The feedback divider produces one event every N cycles of `fb_clk`, where N is the unsigned value of `n_ratio[11:0]`.
- R5: Any `n_ratio` value below 17, including 0, divides by 17.
- R6: With `test_code`=0 and `aux_code`=00, polarity is direct. A feedback rate above the reference rate keeps `pump_dn` active most of the time. A feedback rate below the reference rate keeps `pump_up` active most of the time.
- R7: Polarity is inverted with `test_code`=4, with `test_code`=1, and with `test_code`=0 when `aux_code` is not 00. In inverted polarity, the roles of `pump_up` and `pump_dn` in R6 are exchanged.
- R8: `test_code`=2 holds `pump_up`=1 and `pump_dn`=0. `test_code`=3 holds `pump_up`=0 and `pump_dn`=1.
- R9: `test_code`=5 holds `pump_hiz`=1 with both enables at 0. Every other code keeps `pump_hiz` at 0.
- R10: `test_code`=6 places the reference square wave on `pump_up`. This wave has a period of 128 crystal cycles. `pump_dn` stays at 0.
- R11: `test_code`=7 places the feedback divider output, halved to a square wave of period 2N `fb_clk` cycles, on `pump_dn`. `pump_up` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal-domain clock |
| fb_clk | input | 1 | Prescaled oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| n_ratio | input | 12 | Feedback division ratio N |
| test_code | input | 3 | Pump mode and test selection |
| aux_code | input | 2 | Auxiliary mode bits; non-zero flips polarity in code 0 |
| pump_up | output | 1 | Upper current source enable |
| pump_dn | output | 1 | Lower current source enable |
| pump_hiz | output | 1 | Pump output floated |
| cmp_tick | output | 1 | Comparison-rate tick (crystal/128) |
| snd_tick | output | 1 | Sound-loop reference tick (crystal/512) |
| tone_tick | output | 1 | Audio test tone tick (crystal/4096) |

## Verification
The bench attacks the ratio clamp by routing the feedback divider onto the pump pin with N at 0 and at 3. A missing clamp shows up as a far higher edge count there, or as no toggling at all. Each polarity-selecting combination of test and auxiliary codes is run with the feedback both faster and slower than the reference. A swapped or ignored polarity decode therefore makes the wrong enable dominate. It also measures the exact spacing and nesting of the three ticks, where a counter compared against the wrong bit range would give off-by-a-factor intervals. The forced and floating codes are checked over whole windows, because a decode that leaks the detector into them would show stray pulses.

// File: rtl/uhf_synth_pkg.sv
package uhf_synth_pkg;

    typedef enum logic [2:0] {
        TC_BASE   = 3'd0,
        TC_NOTPG  = 3'd1,
        TC_UP_ON  = 3'd2,
        TC_DN_ON  = 3'd3,
        TC_INVERT = 3'd4,
        TC_HIZ    = 3'd5,
        TC_REF_UP = 3'd6,
        TC_FB_DN  = 3'd7
    } test_code_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic hiz;
    } pump_t;

endpackage

// File: rtl/uhf_ref_divider.sv
module uhf_ref_divider #(
    parameter int REF_LOG2  = 7,
    parameter int SND_LOG2  = 9,
    parameter int TONE_LOG2 = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic cmp_tick,
    output logic snd_tick,
    output logic tone_tick,
    output logic ref_sq
);
    localparam int CW      = TONE_LOG2;
    localparam int GAP_W   = REF_LOG2 + 1;
    localparam int REF_DIV = 1 << REF_LOG2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          cmp;
        logic          snd;
        logic          tone;
    } ref_st_t;

    ref_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + 1'b1;
        st_d.cmp  = &st_q.cnt[REF_LOG2-1:0];
        st_d.snd  = &st_q.cnt[SND_LOG2-1:0];
        st_d.tone = &st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_tick  = st_q.cmp;
    assign snd_tick  = st_q.snd;
    assign tone_tick = st_q.tone;
    assign ref_sq    = st_q.cnt[REF_LOG2-1];

    // interval checker: cycles since the last comparison tick
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (st_q.cmp) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R2
    cmp_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cmp && seen_q) |-> (gap_q == GAP_W'(REF_DIV - 1)));

    // R3
    tick_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tone |-> st_q.snd) and (st_q.snd |-> st_q.cmp));

endmodule

// File: rtl/uhf_fb_divider.sv
module uhf_fb_divider #(
    parameter int N_W   = 12,
    parameter int N_MIN = 17
) (
    input  logic           fb_clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_ratio,
    output logic           fb_sq
);
    localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);

    typedef struct packed {
        logic [N_W-1:0] cnt;
        logic           half;
    } fb_st_t;

    fb_st_t         st_d, st_q;
    logic [1:0]     srst_q;
    logic [N_W-1:0] n_eff;

    // local reset release, synchronous to fb_clk
    always_ff @(posedge fb_clk or negedge rst_n) begin
        if (!rst_n) srst_q <= 2'b00;
        else        srst_q <= {srst_q[0], 1'b1};
    end

    always_comb begin
        n_eff = (n_ratio < N_FLOOR) ? N_FLOOR : n_ratio;
        st_d  = st_q;
        if (st_q.cnt == '0) begin
            st_d.cnt  = n_eff - 1'b1;
            st_d.half = ~st_q.half;
        end else begin
            st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge fb_clk or negedge srst_q[1]) begin
        if (!srst_q[1]) st_q <= '0;
        else            st_q <= st_d;
    end

    assign fb_sq = st_q.half;

    // R5
    reload_floor_chk: assert property (@(posedge fb_clk) disable iff (!srst_q[1])
        (st_q.half != $past(st_q.half)) |-> (st_q.cnt >= N_W'(N_MIN - 1)));

endmodule

// File: rtl/uhf_pfd.sv
module uhf_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_evt,
    input  logic fb_evt,
    output logic lead_ref,
    output logic lead_fb
);
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_st_t;

    pfd_st_t st_d, st_q;

    always_comb begin
        st_d.up = st_q.up | ref_evt;
        st_d.dn = st_q.dn | fb_evt;
        if (st_d.up && st_d.dn) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lead_ref = st_q.up;
    assign lead_fb  = st_q.dn;

    // R6
    up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.up) |-> $past(ref_evt));

    // R6
    dn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dn) |-> $past(fb_evt));

endmodule

// File: rtl/uhf_pump_mode.sv
module uhf_pump_mode
    import uhf_synth_pkg::*;
(
    input  logic [2:0] test_code,
    input  logic [1:0] aux_code,
    input  logic       lead_ref,
    input  logic       lead_fb,
    input  logic       ref_sq,
    input  logic       fb_sq,
    output pump_t      pump
);
    test_code_e code;
    logic       invert;

    always_comb begin
        code   = test_code_e'(test_code);
        invert = (code == TC_INVERT) || (code == TC_NOTPG) ||
                 ((code == TC_BASE) && (aux_code != 2'b00));
        pump   = '0;
        unique case (code)
            TC_BASE, TC_NOTPG, TC_INVERT: begin
                pump.up = invert ? lead_fb  : lead_ref;
                pump.dn = invert ? lead_ref : lead_fb;
            end
            TC_UP_ON:  pump.up  = 1'b1;
            TC_DN_ON:  pump.dn  = 1'b1;
            TC_HIZ:    pump.hiz = 1'b1;
            TC_REF_UP: pump.up  = ref_sq;
            TC_FB_DN:  pump.dn  = fb_sq;
            default:   pump     = '0;
        endcase
    end

endmodule

// File: rtl/uhf_synth_digital.sv
module uhf_synth_digital
    import uhf_synth_pkg::*;
#(
    parameter int N_W       = 12,
    parameter int N_MIN     = 17,
    parameter int REF_LOG2  = 7,
    parameter int SND_LOG2  = 9,
    parameter int TONE_LOG2 = 12,
    parameter int SYNC_LEN  = 2
) (
    input  logic           xtal_clk,
    input  logic           fb_clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_ratio,
    input  logic [2:0]     test_code,
    input  logic [1:0]     aux_code,
    output logic           pump_up,
    output logic           pump_dn,
    output logic           pump_hiz,
    output logic           cmp_tick,
    output logic           snd_tick,
    output logic           tone_tick
);
    localparam int SW = SYNC_LEN + 1;

    typedef struct packed {
        logic [SW-1:0] fb_sync;
        pump_t         pump;
        logic          live;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    ref_sq, fb_sq, fb_evt;
    logic    lead_ref, lead_fb;
    pump_t   pump_nx;

    uhf_ref_divider #(
        .REF_LOG2 (REF_LOG2),
        .SND_LOG2 (SND_LOG2),
        .TONE_LOG2(TONE_LOG2)
    ) u_ref (
        .clk      (xtal_clk),
        .rst_n    (rst_n),
        .cmp_tick (cmp_tick),
        .snd_tick (snd_tick),
        .tone_tick(tone_tick),
        .ref_sq   (ref_sq)
    );

    uhf_fb_divider #(
        .N_W  (N_W),
        .N_MIN(N_MIN)
    ) u_fb (
        .fb_clk (fb_clk),
        .rst_n  (rst_n),
        .n_ratio(n_ratio),
        .fb_sq  (fb_sq)
    );

    // each toggle of the synchronized feedback wave is one divider event
    assign fb_evt = st_q.fb_sync[SW-1] ^ st_q.fb_sync[SW-2];

    uhf_pfd u_pfd (
        .clk     (xtal_clk),
        .rst_n   (rst_n),
        .ref_evt (cmp_tick),
        .fb_evt  (fb_evt),
        .lead_ref(lead_ref),
        .lead_fb (lead_fb)
    );

    uhf_pump_mode u_mode (
        .test_code(test_code),
        .aux_code (aux_code),
        .lead_ref (lead_ref),
        .lead_fb  (lead_fb),
        .ref_sq   (ref_sq),
        .fb_sq    (st_q.fb_sync[SW-2]),
        .pump     (pump_nx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.fb_sync = {st_q.fb_sync[SW-2:0], fb_sq};
        st_d.pump    = pump_nx;
        st_d.live    = 1'b1;
    end

    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pump_up  = st_q.pump.up;
    assign pump_dn  = st_q.pump.dn;
    assign pump_hiz = st_q.pump.hiz;

    // R9
    hiz_quiet_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        pump_hiz |-> (!pump_up && !pump_dn && ($past(test_code) == 3'd5)));

    // R8
    force_up_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        (st_q.live && $past(test_code) == 3'd2) |-> (pump_up && !pump_dn));

    // R8
    force_dn_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        (st_q.live && $past(test_code) == 3'd3) |-> (!pump_up && pump_dn));

    // R11
    fb_route_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        (st_q.live && $past(test_code) == 3'd7) |-> !pump_up);

endmodule

// File: tb/sim_uhf_synth_digital.sv
module sim_uhf_synth_digital;

    localparam int W      = 2048;
    localparam int SETTLE = 600;

    localparam logic [2:0] K_DN_DOM = 3'd0;
    localparam logic [2:0] K_UP_DOM = 3'd1;
    localparam logic [2:0] K_UP_ON  = 3'd2;
    localparam logic [2:0] K_DN_ON  = 3'd3;
    localparam logic [2:0] K_HIZ    = 3'd4;
    localparam logic [2:0] K_UP_TGL = 3'd5;
    localparam logic [2:0] K_DN_TGL = 3'd6;

    typedef struct packed {
        logic [2:0]  code;
        logic [1:0]  aux;
        logic [11:0] n;
        logic [2:0]  kind;
        logic [7:0]  edges;
    } vec_t;

    // fb_clk period 8 ns: event every N*2 crystal cycles; ref every 128
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 12'd17,  K_DN_DOM, 8'd0},   // R6 fast feedback
        '{3'd0, 2'd0, 12'd200, K_UP_DOM, 8'd0},   // R6 slow feedback
        '{3'd4, 2'd0, 12'd17,  K_UP_DOM, 8'd0},   // R7
        '{3'd4, 2'd0, 12'd200, K_DN_DOM, 8'd0},   // R7
        '{3'd1, 2'd0, 12'd17,  K_UP_DOM, 8'd0},   // R7
        '{3'd0, 2'd1, 12'd17,  K_UP_DOM, 8'd0},   // R7
        '{3'd0, 2'd3, 12'd200, K_DN_DOM, 8'd0},   // R7
        '{3'd0, 2'd0, 12'd3,   K_DN_DOM, 8'd0},   // R5
        '{3'd2, 2'd0, 12'd17,  K_UP_ON,  8'd0},   // R8
        '{3'd3, 2'd0, 12'd17,  K_DN_ON,  8'd0},   // R8
        '{3'd5, 2'd0, 12'd17,  K_HIZ,    8'd0},   // R9
        '{3'd6, 2'd0, 12'd17,  K_UP_TGL, 8'd16},  // R10
        '{3'd7, 2'd0, 12'd20,  K_DN_TGL, 8'd26},  // R4
        '{3'd7, 2'd0, 12'd3,   K_DN_TGL, 8'd30},  // R5
        '{3'd7, 2'd0, 12'd0,   K_DN_TGL, 8'd30},  // R5
        '{3'd7, 2'd0, 12'd100, K_DN_TGL, 8'd5}    // R11
    };

    logic        xtal_clk = 1'b0;
    logic        fb_clk   = 1'b0;
    logic        rst_n    = 1'b0;
    logic [11:0] n_ratio  = 12'd17;
    logic [2:0]  test_code = 3'd0;
    logic [1:0]  aux_code  = 2'd0;
    logic        pump_up, pump_dn, pump_hiz, cmp_tick, snd_tick, tone_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 xtal_clk = ~xtal_clk;
    always #4 fb_clk   = ~fb_clk;

    uhf_synth_digital u0 (
        .xtal_clk (xtal_clk),
        .fb_clk   (fb_clk),
        .rst_n    (rst_n),
        .n_ratio  (n_ratio),
        .test_code(test_code),
        .aux_code (aux_code),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .pump_hiz (pump_hiz),
        .cmp_tick (cmp_tick),
        .snd_tick (snd_tick),
        .tone_tick(tone_tick)
    );

    task automatic cyc();
        @(posedge xtal_clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(vec_t v);
        case (v.kind)
            K_DN_DOM, K_UP_DOM:
                if (v.n < 12'd17)                     return "R5";
                else if (v.code == 3'd0 && v.aux == 2'd0) return "R6";
                else                                  return "R7";
            K_UP_ON, K_DN_ON: return "R8";
            K_HIZ:            return "R9";
            K_UP_TGL:         return "R10";
            default:
                if (v.n < 12'd17)       return "R5";
                else if (v.n == 12'd20) return "R4";
                else                    return "R11";
        endcase
    endfunction

    task automatic gap_of(input int which, output int gap);
        logic t;
        gap = 0;
        do begin
            cyc();
            t = (which == 0) ? cmp_tick : (which == 1) ? snd_tick : tone_tick;
        end while (!t);
        do begin
            cyc();
            gap++;
            t = (which == 0) ? cmp_tick : (which == 1) ? snd_tick : tone_tick;
        end while (!t && gap < 10000);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int g;
        int nc, ns, nt, bad;
        // R1: outputs quiet while reset is held
        repeat (5) cyc();
        check({pump_up, pump_dn, pump_hiz, cmp_tick, snd_tick, tone_tick} == 6'd0,
              "R1", "outputs in reset",
              int'({pump_up, pump_dn, pump_hiz, cmp_tick, snd_tick, tone_tick}), 0);
        @(negedge xtal_clk);
        rst_n = 1'b1;

        // R2 / R3: tick spacing
        gap_of(0, g); check(g == 128,  "R2", "cmp_tick spacing", g, 128);
        gap_of(1, g); check(g == 512,  "R3", "snd_tick spacing", g, 512);
        gap_of(2, g); check(g == 4096, "R3", "tone_tick spacing", g, 4096);
        nc = 0; ns = 0; nt = 0; bad = 0;
        for (int i = 0; i < 8192; i++) begin
            cyc();
            nc += int'(cmp_tick);
            ns += int'(snd_tick);
            nt += int'(tone_tick);
            if ((tone_tick && !snd_tick) || (snd_tick && !cmp_tick)) bad++;
        end
        check(nc == 64, "R2", "cmp_tick count", nc, 64);
        check(ns == 16, "R3", "snd_tick count", ns, 16);
        check(nt == 2,  "R3", "tone_tick count", nt, 2);
        check(bad == 0, "R3", "tick nesting violations", bad, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            int up_c, dn_c, hz_c, up_e, dn_e;
            logic pu, pd;
            string r;
            @(negedge xtal_clk);
            test_code = VECS[v].code;
            aux_code  = VECS[v].aux;
            n_ratio   = VECS[v].n;
            repeat (SETTLE) cyc();
            up_c = 0; dn_c = 0; hz_c = 0; up_e = 0; dn_e = 0;
            pu = pump_up; pd = pump_dn;
            for (int i = 0; i < W; i++) begin
                cyc();
                up_c += int'(pump_up);
                dn_c += int'(pump_dn);
                hz_c += int'(pump_hiz);
                if (pump_up && !pu) up_e++;
                if (pump_dn && !pd) dn_e++;
                pu = pump_up; pd = pump_dn;
            end
            r = req_of(VECS[v]);
            case (VECS[v].kind)
                K_DN_DOM: check(dn_c > 0 && dn_c > 4 * up_c, r, "dn dominance (dn cycles)", dn_c, 4 * up_c + 1);
                K_UP_DOM: check(up_c > 0 && up_c > 4 * dn_c, r, "up dominance (up cycles)", up_c, 4 * dn_c + 1);
                K_UP_ON:  check(up_c == W && dn_c == 0, r, "forced up cycles", up_c - dn_c, W);
                K_DN_ON:  check(dn_c == W && up_c == 0, r, "forced dn cycles", dn_c - up_c, W);
                K_HIZ:    check(hz_c == W && up_c == 0 && dn_c == 0, r, "hiz cycles", hz_c - up_c - dn_c, W);
                K_UP_TGL: check(dn_c == 0 && up_e >= int'(VECS[v].edges) - 1 && up_e <= int'(VECS[v].edges) + 1,
                                r, "ref wave edges on up", up_e, int'(VECS[v].edges));
                default:  check(up_c == 0 && dn_e >= int'(VECS[v].edges) - 1 && dn_e <= int'(VECS[v].edges) + 1,
                                r, "fb wave edges on dn", dn_e, int'(VECS[v].edges));
            endcase
            if (VECS[v].kind != K_HIZ)
                check(hz_c == 0, "R9", "hiz outside code 5", hz_c, 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule